// File: doc/BRIEF.md
# Reset-Held Debug Pin Unlock

This block decides, each time the device comes out of reset, whether a shared pin acts as a debug pin or stays a general-purpose I/O. While the external reset level is held low it watches the bytes that an upstream serial receiver presents on a byte-valid strobe. A settling timer must first run for a set number of cycles. After that, the block compares the incoming bytes with a fixed five-byte sequence. The sequence starts with the autobaud character 80H and continues with a 32-bit key sent as EBH, 5AH, 70H, CDH.

The result is sampled on the rising edge of the reset level and held for as long as reset stays released. If the sequence was complete at that edge, the pin becomes a debug pin. If it was not, the pin stays GPIO. The next assertion of reset clears the decision, and a new unlock attempt begins. The bit-level receiver, the baud-rate measurement and the debugger commands sit outside this block.

Top module: `dbg_pin_unlock`

## Requirements
- R1: After the power-on reset `por_n` is released, `debug_pin_en` is 0 and `gpio_sel` is 1.
- R2: A byte strobe has no effect on the matcher unless `rst_pin_n` has been low for at least `SETTLE_CYCLES` consecutive clock cycles. This covers strobes that arrive early in the reset-held period and strobes that arrive while reset is released.
- R3: The accepted byte sequence 80H, EBH, 5AH, 70H, CDH, followed by a rising edge of `rst_pin_n`, sets `debug_pin_en` to 1 and `gpio_sel` to 0 one clock later.
- R4: A byte that differs from the expected byte sends the matcher back to waiting for 80H. The mismatching byte itself is discarded, even when it equals 80H.
- R5: Every byte after the first 80H counts as a match only while `baud_locked` is 1. A key byte accepted while `baud_locked` is 0 is treated as a mismatch.
- R6: If `rst_pin_n` rises before the full sequence has been accepted, `debug_pin_en` stays 0 and `gpio_sel` stays 1.
- R7: Once the sequence is complete, later bytes accepted before reset is released, whatever their value, do not cancel the unlock.
- R8: While `rst_pin_n` stays high, the pin role does not change, whatever the byte activity. A falling edge of `rst_pin_n` returns the role to GPIO on the next clock and clears any unlock progress.
- R9: `gpio_sel` is at every cycle the inverse of `debug_pin_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Active-low power-on reset of the block's own state |
| rst_pin_n | input | 1 | Active-low device reset level, synchronous to clk |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| baud_locked | input | 1 | High once the baud measurement has completed |
| debug_pin_en | output | 1 | Shared pin acts as debug pin |
| gpio_sel | output | 1 | Shared pin acts as general-purpose I/O |

## Verification
The assertions check the following on every cycle:
- The pin role changes only at a reset edge, and it drops on a falling edge.
- A completed unlock stays set until reset is asserted again.
- Strobes outside the settled reset window leave the matcher's position untouched.
- The window is closed whenever reset is released.

Other behaviours depend on the order of bytes and on their values, so only the bench's scenarios can show them:
- A wrong byte, including a stray 80H, restarts the sequence.
- The autobaud flag gates the key bytes.
- Sending the sequence too early or too late leaves the pin as GPIO.

// File: rtl/dbg_unlock_pkg.sv
package dbg_unlock_pkg;

  localparam int SEQ_LEN = 5;

  // Byte n of the unlock sequence: the autobaud character first,
  // then the key from its most significant byte down.
  function automatic logic [7:0] seq_byte(input int n,
                                          input logic [7:0] autobaud,
                                          input logic [31:0] key);
    logic [7:0] b;
    if (n == 0) begin
      b = autobaud;
    end else begin
      b = key[(4 - n) * 8 +: 8];
    end
    return b;
  endfunction

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_CYCLES = 100000,
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             in_reset,
  output logic             window_open,
  output logic [CNT_W-1:0] held_cycles
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYCLES);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      held_cycles <= '0;
    end else if (!in_reset) begin
      held_cycles <= '0;
    end else if (held_cycles != LIMIT) begin
      held_cycles <= held_cycles + 1'b1;
    end
  end

  assign window_open = (held_cycles == LIMIT);

  // R2: a released reset always closes the window at the next edge
  assert_window_closed_R2: assert property (@(posedge clk) disable iff (!por_n)
    !in_reset |=> !window_open);

endmodule

// File: rtl/key_matcher.sv
module key_matcher
  import dbg_unlock_pkg::*;
#(
  parameter logic [7:0]  AUTOBAUD = 8'h80,
  parameter logic [31:0] KEY      = 32'hEB5A70CD,
  localparam int IDX_W = $clog2(SEQ_LEN + 1)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             clear,
  input  logic             accept_en,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             baud_locked,
  output logic [IDX_W-1:0] seq_pos,
  output logic             key_ok
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(SEQ_LEN - 1);

  logic [7:0] expect_tab [SEQ_LEN];

  for (genvar g = 0; g < SEQ_LEN; g++) begin : g_tab
    assign expect_tab[g] = seq_byte(g, AUTOBAUD, KEY);
  end

  logic take;
  logic hit;

  assign take = accept_en && byte_valid && !key_ok;
  assign hit  = (byte_data == expect_tab[seq_pos]) &&
                ((seq_pos == '0) || baud_locked);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      seq_pos <= '0;
      key_ok  <= 1'b0;
    end else if (clear) begin
      seq_pos <= '0;
      key_ok  <= 1'b0;
    end else if (take) begin
      if (!hit) begin
        seq_pos <= '0;
      end else if (seq_pos == LAST) begin
        seq_pos <= '0;
        key_ok  <= 1'b1;
      end else begin
        seq_pos <= seq_pos + 1'b1;
      end
    end
  end

  // R2: strobes outside the accept window leave the position alone
  assert_ignore_outside_R2: assert property (@(posedge clk) disable iff (!por_n)
    (byte_valid && !accept_en && !clear) |=> $stable(seq_pos));

  // R7: a completed unlock survives until the next clear
  assert_key_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
    (key_ok && !clear) |=> key_ok);

  // R4: position never runs past the last sequence byte
  assert_pos_bounded_R4: assert property (@(posedge clk) disable iff (!por_n)
    seq_pos <= LAST);

endmodule

// File: rtl/role_latch.sv
module role_latch (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin_n,
  input  logic key_ok,
  output logic rst_rise,
  output logic rst_fall,
  output logic debug_pin_en
);

  logic rst_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_q <= 1'b1;
    end else begin
      rst_q <= rst_pin_n;
    end
  end

  assign rst_rise = rst_pin_n && !rst_q;
  assign rst_fall = !rst_pin_n && rst_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      debug_pin_en <= 1'b0;
    end else if (rst_fall) begin
      debug_pin_en <= 1'b0;
    end else if (rst_rise) begin
      debug_pin_en <= key_ok;
    end
  end

  // R8: role only moves at a reset edge
  assert_role_held_R8: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_rise && !rst_fall) |=> $stable(debug_pin_en));

  // R8: reset assertion returns the pin to GPIO
  assert_fall_clears_R8: assert property (@(posedge clk) disable iff (!por_n)
    rst_fall |=> !debug_pin_en);

endmodule

// File: rtl/dbg_pin_unlock.sv
module dbg_pin_unlock
  import dbg_unlock_pkg::*;
#(
  parameter int          SETTLE_CYCLES = 100000,
  parameter logic [7:0]  AUTOBAUD      = 8'h80,
  parameter logic [31:0] KEY           = 32'hEB5A70CD
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_pin_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       baud_locked,
  output logic       debug_pin_en,
  output logic       gpio_sel
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam int IDX_W = $clog2(SEQ_LEN + 1);

  logic             in_reset;
  logic             window_open;
  logic [CNT_W-1:0] held_cycles;
  logic             accept_en;
  logic [IDX_W-1:0] seq_pos;
  logic             key_ok;
  logic             rst_rise;
  logic             rst_fall;

  assign in_reset  = !rst_pin_n;
  assign accept_en = window_open && in_reset;

  settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk         (clk),
    .por_n       (por_n),
    .in_reset    (in_reset),
    .window_open (window_open),
    .held_cycles (held_cycles)
  );

  key_matcher #(.AUTOBAUD(AUTOBAUD), .KEY(KEY)) u_match (
    .clk         (clk),
    .por_n       (por_n),
    .clear       (rst_fall),
    .accept_en   (accept_en),
    .byte_valid  (rx_valid),
    .byte_data   (rx_byte),
    .baud_locked (baud_locked),
    .seq_pos     (seq_pos),
    .key_ok      (key_ok)
  );

  role_latch u_role (
    .clk          (clk),
    .por_n        (por_n),
    .rst_pin_n    (rst_pin_n),
    .key_ok       (key_ok),
    .rst_rise     (rst_rise),
    .rst_fall     (rst_fall),
    .debug_pin_en (debug_pin_en)
  );

  assign gpio_sel = !debug_pin_en;

  // R9: exactly one role is selected at any time
  assert_one_role_R9: assert property (@(posedge clk) disable iff (!por_n)
    $onehot({debug_pin_en, gpio_sel}));

  // R3: an unlock is only granted at a reset release with a complete key
  assert_grant_needs_key_R3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(debug_pin_en) |-> $past(key_ok) && $past(rst_rise));

endmodule

// File: tb/dbg_pin_unlock_test.sv
`timescale 1ns/1ps
module dbg_pin_unlock_test;

  localparam int SETTLE = 40;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       rst_pin_n = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       baud_locked = 1'b0;
  logic       debug_pin_en;
  logic       gpio_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dbg_pin_unlock #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk          (clk),
    .por_n        (por_n),
    .rst_pin_n    (rst_pin_n),
    .rx_valid     (rx_valid),
    .rx_byte      (rx_byte),
    .baud_locked  (baud_locked),
    .debug_pin_en (debug_pin_en),
    .gpio_sel     (gpio_sel)
  );

  task automatic check_role(input string req, input logic exp_dbg);
    checks++;
    if (debug_pin_en !== exp_dbg || gpio_sel !== !exp_dbg) begin
      errors++;
      $display("FAIL %s: debug_pin_en=%b gpio_sel=%b expected %b/%b",
               req, debug_pin_en, gpio_sel, exp_dbg, !exp_dbg);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic locked);
    @(negedge clk);
    rx_valid    = 1'b1;
    rx_byte     = b;
    baud_locked = locked;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_seq(input logic locked);
    send(8'h80, locked);
    send(8'hEB, 1'b1);
    send(8'h5A, 1'b1);
    send(8'h70, 1'b1);
    send(8'hCD, 1'b1);
  endtask

  task automatic hold_reset_settled();
    @(negedge clk);
    rst_pin_n = 1'b0;
    idle(SETTLE + 3);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_pin_n = 1'b1;
    idle(2);
  endtask

  task automatic t_por();
    idle(3);
    check_role("R1 after por", 1'b0);
    por_n = 1'b1;
    idle(3);
    check_role("R1 after por release", 1'b0);
  endtask

  task automatic t_good_unlock();
    hold_reset_settled();
    send_seq(1'b0);
    idle(2);
    check_role("R8 role during reset", 1'b0);
    release_reset();
    check_role("R3 unlock granted", 1'b1);
    send_seq(1'b1);
    send(8'h00, 1'b1);
    idle(4);
    check_role("R8 held with traffic", 1'b1);
    check_role("R9 complement", 1'b1);
    @(negedge clk);
    rst_pin_n = 1'b0;
    idle(2);
    check_role("R8 cleared on assert", 1'b0);
    idle(SETTLE + 3);
    release_reset();
    check_role("R8 progress cleared", 1'b0);
  endtask

  task automatic t_early();
    @(negedge clk);
    rst_pin_n = 1'b0;
    idle(3);
    send_seq(1'b1);
    idle(SETTLE);
    release_reset();
    check_role("R2 early bytes ignored", 1'b0);
  endtask

  task automatic t_mismatch();
    hold_reset_settled();
    send(8'h80, 1'b1);
    send(8'hEB, 1'b1);
    send(8'h11, 1'b1);
    send(8'h5A, 1'b1);
    send(8'h70, 1'b1);
    send(8'hCD, 1'b1);
    release_reset();
    check_role("R4 wrong byte restarts", 1'b0);
    hold_reset_settled();
    send(8'h80, 1'b1);
    send(8'h80, 1'b1);
    send(8'hEB, 1'b1);
    send(8'h5A, 1'b1);
    send(8'h70, 1'b1);
    send(8'hCD, 1'b1);
    release_reset();
    check_role("R4 stray 80H discarded", 1'b0);
    hold_reset_settled();
    send(8'h80, 1'b1);
    send(8'h5A, 1'b1);
    send_seq(1'b1);
    release_reset();
    check_role("R4 recovery after mismatch", 1'b1);
  endtask

  task automatic t_baud();
    hold_reset_settled();
    send(8'h80, 1'b0);
    send(8'hEB, 1'b0);
    send(8'h5A, 1'b1);
    send(8'h70, 1'b1);
    send(8'hCD, 1'b1);
    release_reset();
    check_role("R5 key needs baud lock", 1'b0);
    hold_reset_settled();
    send_seq(1'b0);
    release_reset();
    check_role("R5 autobaud byte without lock", 1'b1);
  endtask

  task automatic t_partial();
    hold_reset_settled();
    send(8'h80, 1'b1);
    send(8'hEB, 1'b1);
    send(8'h5A, 1'b1);
    send(8'h70, 1'b1);
    release_reset();
    check_role("R6 partial key", 1'b0);
  endtask

  task automatic t_extra();
    hold_reset_settled();
    send_seq(1'b1);
    send(8'h33, 1'b1);
    send(8'h80, 1'b0);
    release_reset();
    check_role("R7 extra bytes keep unlock", 1'b1);
  endtask

  task automatic t_high_traffic();
    @(negedge clk);
    rst_pin_n = 1'b0;
    idle(2);
    check_role("R8 assert clears", 1'b0);
    release_reset();
    send_seq(1'b1);
    idle(2);
    check_role("R2 bytes while released", 1'b0);
    @(negedge clk);
    rst_pin_n = 1'b0;
    idle(2);
    release_reset();
    check_role("R2 no carry over", 1'b0);
  endtask

  initial begin
    t_por();
    t_good_unlock();
    t_early();
    t_mismatch();
    t_baud();
    t_partial();
    t_extra();
    t_high_traffic();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: done=0 expected 1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule